// File: doc/BRIEF.md
# Exec-Masked Vector Register Writeback

This block sits between a vector execution pipeline and a banked vector register file. Each cycle it may accept one writeback: a per-lane result of one or two 32-bit words, a logical destination register number and the wavefront's base in the physical register file. It then issues per-lane write strobes and data on two register-file write ports. A single-word result uses only the low port. A two-word result drives both ports in the same cycle: the low halves go to the destination register and the high halves go to the register after it.

Only lanes enabled by an execution mask are written. The mask normally comes from the wavefront's live exec mask. A load instruction uses instead the mask that was captured when the load issued, because the live mask may have changed while the data was in flight. An ignore-exec flag on the instruction enables every lane whatever the mask holds. Each destination register number, the low one and the one after it, is mapped to a physical register on its own, by modular addition of the wavefront base. The register-file storage itself lies outside this block.

Top module: `vec_wb_exec`

## Requirements
- R1: With `wb_valid` high and `ignore_exec` low, lane i is enabled exactly when bit i of the selected exec mask is set (lane 0 is bit 0). Enabled lanes assert their strobe and disabled lanes leave it low.
- R2: The selected mask is `inst_exec` when `is_load` is 1 and `wave_exec` when `is_load` is 0.
- R3: With `wb_valid` and `ignore_exec` both high, every lane strobe of the low port is asserted, whatever either mask holds.
- R4: Lane i of `lo_data` carries bits 31:0 of lane i's result. Lane i of `hi_data` carries bits 63:32. Lane i of the result occupies bits [64*i+63 : 64*i] of `wb_data`.
- R5: With `wb_wide` = 1 (two words), `hi_we` equals `lo_we`. With `wb_wide` = 0 (one word), `hi_we` is all zero.
- R6: `lo_idx` = (`wave_base` + `wb_dst`) mod NUM_PREGS and `hi_idx` = (`wave_base` + `wb_dst` + 1) mod NUM_PREGS, each mapped separately, so a wide result at the last physical register wraps to register 0. Both inputs must be below NUM_PREGS.
- R7: With `wb_valid` low, both ports' strobes are all zero in the following cycle.
- R8: A register lane whose strobe is low keeps its previous contents bit for bit. Enabled lanes of both registers are written in the same cycle.
- R9: Outputs for a writeback presented in cycle k appear after the clock edge that ends cycle k, one cycle of latency, on both ports together.
- R10: While `rst_n` is low, and in the first cycle after it, all write strobes are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wb_valid | input | 1 | A writeback is presented this cycle |
| wb_wide | input | 1 | 0: one word per lane, 1: two words per lane |
| wb_dst | input | IDX_W | Logical destination register |
| wave_base | input | IDX_W | Wavefront base in the physical register file |
| is_load | input | 1 | Instruction is a load; use the captured mask |
| ignore_exec | input | 1 | Enable all lanes regardless of mask |
| wave_exec | input | NUM_LANES | Wavefront's live exec mask |
| inst_exec | input | NUM_LANES | Exec mask captured with the instruction |
| wb_data | input | NUM_LANES*64 | Per-lane result, 64 bits per lane |
| lo_we | output | NUM_LANES | Low-port per-lane write strobes |
| lo_idx | output | IDX_W | Low-port physical register |
| lo_data | output | NUM_LANES*32 | Low-port per-lane write data |
| hi_we | output | NUM_LANES | High-port per-lane write strobes |
| hi_idx | output | IDX_W | High-port physical register |
| hi_data | output | NUM_LANES*32 | High-port per-lane write data |

## Verification
Every cycle, the assertions check that the high port's strobes never differ from the low port's when they are active, and that the high register is the modular successor of the low one. They also check that an idle input gives quiet strobes one cycle later, that ignore-exec opens all lanes, that no lane outside the chosen mask source is written, and that a mapped index stays inside the physical file. Only the bench's scenarios can show that the selected lanes and the data words are the right ones, and that untouched lanes of a modelled register file keep their old values across long sequences of masked writes. Those scenarios sweep every mask value for both mask sources, and cover wrap-around at the end of the file.

// File: rtl/vwb_pkg.sv
package vwb_pkg;

   // Writeback width: one or two 32-bit words per lane
   typedef enum logic {
      WB_ONE_WORD = 1'b0,
      WB_TWO_WORD = 1'b1
   } wb_width_e;

   localparam int unsigned WB_PORTS = 2;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/vwb_mask_sel.sv
module vwb_mask_sel #(
   parameter int unsigned NUM_LANES = 64
) (
   input  logic                 is_load,
   input  logic                 ignore_exec,
   input  logic [NUM_LANES-1:0] wave_exec,
   input  logic [NUM_LANES-1:0] inst_exec,
   output logic [NUM_LANES-1:0] lane_en
);

   logic [NUM_LANES-1:0] src_mask;

   // Loads carry their own mask; the live mask may have moved on
   always_comb begin
      if (is_load) src_mask = inst_exec;
      else         src_mask = wave_exec;
   end

   always_comb begin
      if (ignore_exec) lane_en = '1;
      else             lane_en = src_mask;
   end

endmodule

// File: rtl/vwb_reg_map.sv
module vwb_reg_map #(
   parameter int unsigned NUM_PREGS = 256,
   parameter int unsigned OFFSET    = 0,
   localparam int unsigned IDX_W    = $clog2(NUM_PREGS),
   localparam int unsigned SUM_W    = IDX_W + 2
) (
   input  logic [IDX_W-1:0] base,
   input  logic [IDX_W-1:0] idx,
   output logic [IDX_W-1:0] phys
);

   logic [SUM_W-1:0] sum;

   assign sum = SUM_W'(base) + SUM_W'(idx) + SUM_W'(OFFSET);

   generate
      if (OFFSET > 1) begin : g_bad_offset
         $error("vwb_reg_map: OFFSET must be 0 or 1");
      end
      if (vwb_pkg::is_pow2(NUM_PREGS)) begin : g_wrap_free
         // Power-of-two file: dropping the carry is the modulus
         assign phys = sum[IDX_W-1:0];
      end else begin : g_wrap_sub
         // Inputs below NUM_PREGS keep sum below 2*NUM_PREGS: one subtract
         logic [SUM_W-1:0] folded;
         always_comb begin
            if (sum >= SUM_W'(NUM_PREGS)) folded = sum - SUM_W'(NUM_PREGS);
            else                          folded = sum;
         end
         assign phys = folded[IDX_W-1:0];
      end
   endgenerate

   // R6: a legal base and register always land inside the file
   always_comb begin
      if (!$isunknown({base, idx}) &&
          (int'(base) < int'(NUM_PREGS)) && (int'(idx) < int'(NUM_PREGS))) begin
         p_phys_in_range_r6: assert (int'(phys) < int'(NUM_PREGS))
            else $error("mapped register %0d outside file", phys);
      end
   end

endmodule

// File: rtl/vwb_lane_split.sv
module vwb_lane_split #(
   parameter int unsigned NUM_LANES = 64,
   parameter int unsigned WORD_W    = 32,
   localparam int unsigned LANE_W   = 2 * WORD_W
) (
   input  logic [NUM_LANES*LANE_W-1:0] lane_data,
   output logic [NUM_LANES*WORD_W-1:0] lo_word,
   output logic [NUM_LANES*WORD_W-1:0] hi_word
);

   generate
      for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
         assign lo_word[l*WORD_W +: WORD_W] = lane_data[l*LANE_W          +: WORD_W];
         assign hi_word[l*WORD_W +: WORD_W] = lane_data[l*LANE_W + WORD_W +: WORD_W];
      end
   endgenerate

endmodule

// File: rtl/vwb_out_stage.sv
module vwb_out_stage #(
   parameter int unsigned NUM_LANES = 64,
   parameter int unsigned WORD_W    = 32,
   parameter int unsigned IDX_W     = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_LANES-1:0]        we_in,
   input  logic [IDX_W-1:0]            idx_in,
   input  logic [NUM_LANES*WORD_W-1:0] data_in,
   output logic [NUM_LANES-1:0]        we_q,
   output logic [IDX_W-1:0]            idx_q,
   output logic [NUM_LANES*WORD_W-1:0] data_q
);

   logic any_we;
   assign any_we = |we_in;

   // Strobes reset; index and data only move when a lane writes
   always_ff @(posedge clk) begin
      if (!rst_n) we_q <= '0;
      else        we_q <= we_in;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q  <= '0;
         data_q <= '0;
      end else if (any_we) begin
         idx_q  <= idx_in;
         data_q <= data_in;
      end
   end

   // R7: no request in means no strobe out one cycle later
   p_quiet_when_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (we_in == '0) |=> (we_q == '0));

   // R9: a stored strobe pattern is the one presented a cycle earlier
   p_strobe_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (we_in != '0) |=> (we_q == $past(we_in)));

endmodule

// File: rtl/vec_wb_exec.sv
module vec_wb_exec #(
   parameter int unsigned NUM_LANES = 64,
   parameter int unsigned WORD_W    = 32,
   parameter int unsigned NUM_PREGS = 256,
   localparam int unsigned IDX_W    = $clog2(NUM_PREGS),
   localparam int unsigned LANE_W   = 2 * WORD_W
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wb_valid,
   input  logic                        wb_wide,
   input  logic [IDX_W-1:0]            wb_dst,
   input  logic [IDX_W-1:0]            wave_base,
   input  logic                        is_load,
   input  logic                        ignore_exec,
   input  logic [NUM_LANES-1:0]        wave_exec,
   input  logic [NUM_LANES-1:0]        inst_exec,
   input  logic [NUM_LANES*LANE_W-1:0] wb_data,
   output logic [NUM_LANES-1:0]        lo_we,
   output logic [IDX_W-1:0]            lo_idx,
   output logic [NUM_LANES*WORD_W-1:0] lo_data,
   output logic [NUM_LANES-1:0]        hi_we,
   output logic [IDX_W-1:0]            hi_idx,
   output logic [NUM_LANES*WORD_W-1:0] hi_data
);

   import vwb_pkg::*;

   generate
      if (NUM_LANES < 1 || NUM_LANES > 64) begin : g_bad_lanes
         $error("vec_wb_exec: NUM_LANES must be 1..64");
      end
      if (NUM_PREGS < 2) begin : g_bad_pregs
         $error("vec_wb_exec: NUM_PREGS must be at least 2");
      end
      if (WORD_W < 1) begin : g_bad_word
         $error("vec_wb_exec: WORD_W must be positive");
      end
   endgenerate

   logic [NUM_LANES-1:0] lane_en;

   vwb_mask_sel #(.NUM_LANES(NUM_LANES)) u_mask (
      .is_load    (is_load),
      .ignore_exec(ignore_exec),
      .wave_exec  (wave_exec),
      .inst_exec  (inst_exec),
      .lane_en    (lane_en)
   );

   logic [WB_PORTS-1:0][NUM_LANES*WORD_W-1:0] port_word;

   vwb_lane_split #(.NUM_LANES(NUM_LANES), .WORD_W(WORD_W)) u_split (
      .lane_data(wb_data),
      .lo_word  (port_word[0]),
      .hi_word  (port_word[1])
   );

   logic [WB_PORTS-1:0][IDX_W-1:0]            port_phys;
   logic [WB_PORTS-1:0][NUM_LANES-1:0]        port_we_d;
   logic [WB_PORTS-1:0][NUM_LANES-1:0]        port_we_q;
   logic [WB_PORTS-1:0][IDX_W-1:0]            port_idx_q;
   logic [WB_PORTS-1:0][NUM_LANES*WORD_W-1:0] port_data_q;

   // Port p serves word p of the lane; port 1 only for two-word results
   generate
      for (genvar p = 0; p < WB_PORTS; p++) begin : g_port
         logic port_active;
         if (p == 0) begin : g_lo
            assign port_active = wb_valid;
         end else begin : g_hi
            assign port_active = wb_valid && (wb_width_e'(wb_wide) == WB_TWO_WORD);
         end

         assign port_we_d[p] = port_active ? lane_en : '0;

         vwb_reg_map #(.NUM_PREGS(NUM_PREGS), .OFFSET(p)) u_map (
            .base(wave_base),
            .idx (wb_dst),
            .phys(port_phys[p])
         );

         vwb_out_stage #(.NUM_LANES(NUM_LANES), .WORD_W(WORD_W), .IDX_W(IDX_W)) u_out (
            .clk    (clk),
            .rst_n  (rst_n),
            .we_in  (port_we_d[p]),
            .idx_in (port_phys[p]),
            .data_in(port_word[p]),
            .we_q   (port_we_q[p]),
            .idx_q  (port_idx_q[p]),
            .data_q (port_data_q[p])
         );
      end
   endgenerate

   assign lo_we   = port_we_q[0];
   assign lo_idx  = port_idx_q[0];
   assign lo_data = port_data_q[0];
   assign hi_we   = port_we_q[1];
   assign hi_idx  = port_idx_q[1];
   assign hi_data = port_data_q[1];

   // Successor of the low register, folded at the file end
   logic [IDX_W:0]   lo_inc;
   logic [IDX_W-1:0] lo_succ;
   assign lo_inc  = {1'b0, lo_idx} + 1'b1;
   assign lo_succ = (lo_inc == (IDX_W+1)'(NUM_PREGS)) ? '0 : lo_inc[IDX_W-1:0];

   // R5: the high port never strobes lanes the low port does not
   p_hi_follows_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_we != '0) |-> (hi_we == lo_we));

   // R5: one-word results leave the high port silent
   p_narrow_hi_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid && !wb_wide) |=> (hi_we == '0));

   // R6: the two registers of a wide result are adjacent modulo the file
   p_hi_adjacent_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_we != '0) |-> (hi_idx == lo_succ));

   // R3: ignore-exec opens every lane
   p_ignore_all_lanes_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid && ignore_exec) |=> (lo_we == '1));

   // R2: a load never writes a lane outside its captured mask
   p_load_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid && !ignore_exec && is_load) |=> ((lo_we & ~$past(inst_exec)) == '0));

   // R2: a non-load never writes a lane outside the live mask
   p_live_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid && !ignore_exec && !is_load) |=> ((lo_we & ~$past(wave_exec)) == '0));

endmodule

// File: tb/sim_vec_wb_exec.sv
module sim_vec_wb_exec;

   localparam int CLK_PERIOD = 10;
   localparam int N  = 8;
   localparam int W  = 32;
   localparam int P  = 12;
   localparam int IW = $clog2(P);

   logic            clk = 1'b0;
   logic            rst_n;
   logic            wb_valid, wb_wide, is_load, ignore_exec;
   logic [IW-1:0]   wb_dst, wave_base;
   logic [N-1:0]    wave_exec, inst_exec;
   logic [N*64-1:0] wb_data;
   logic [N-1:0]    lo_we, hi_we;
   logic [IW-1:0]   lo_idx, hi_idx;
   logic [N*W-1:0]  lo_data, hi_data;

   always #(CLK_PERIOD/2) clk = ~clk;

   vec_wb_exec #(.NUM_LANES(N), .WORD_W(W), .NUM_PREGS(P)) u0 (
      .clk(clk), .rst_n(rst_n), .wb_valid(wb_valid), .wb_wide(wb_wide),
      .wb_dst(wb_dst), .wave_base(wave_base), .is_load(is_load),
      .ignore_exec(ignore_exec), .wave_exec(wave_exec), .inst_exec(inst_exec),
      .wb_data(wb_data), .lo_we(lo_we), .lo_idx(lo_idx), .lo_data(lo_data),
      .hi_we(hi_we), .hi_idx(hi_idx), .hi_data(hi_data)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   logic [W-1:0] ref_rf [P][N];
   logic [W-1:0] dut_rf [P][N];

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // One writeback: drive at a falling edge, sample at the next falling edge (R9)
   task automatic do_wb(input bit v, input bit wide, input int dst, input int base,
                        input bit ld, input bit ign, input logic [N-1:0] wmask,
                        input logic [N-1:0] imask, input int seed);
      logic [N-1:0] en, e_lo, e_hi;
      int e_lo_idx, e_hi_idx;
      logic [W-1:0] lo_w [N];
      logic [W-1:0] hi_w [N];
      wb_valid = v; wb_wide = wide; wb_dst = IW'(dst); wave_base = IW'(base);
      is_load = ld; ignore_exec = ign; wave_exec = wmask; inst_exec = imask;
      for (int l = 0; l < N; l++) begin
         lo_w[l] = 32'(seed * 32'h9E3779B1) ^ 32'(l * 32'h01010101);
         hi_w[l] = ~(32'(seed * 7) + 32'(l * 32'h00011111));
         wb_data[l*64 +: 32]      = lo_w[l];
         wb_data[l*64 + 32 +: 32] = hi_w[l];
      end
      // R1 R2 R3: expected enables from the requirements
      en   = ign ? '1 : (ld ? imask : wmask);
      e_lo = v ? en : '0;
      e_hi = (v && wide) ? en : '0;
      e_lo_idx = (base + dst) % P;
      e_hi_idx = (base + dst + 1) % P;
      @(posedge clk);
      @(negedge clk);
      check(lo_we == e_lo, "R1/R2/R3/R7 lo_we", 64'(lo_we), 64'(e_lo));
      check(hi_we == e_hi, "R5/R7 hi_we", 64'(hi_we), 64'(e_hi));
      if (e_lo != '0) begin
         check(int'(lo_idx) == e_lo_idx, "R6 lo_idx", 64'(lo_idx), 64'(e_lo_idx));
         for (int l = 0; l < N; l++)
            check(lo_data[l*W +: W] == lo_w[l], "R4 lo_data", 64'(lo_data[l*W +: W]), 64'(lo_w[l]));
      end
      if (e_hi != '0) begin
         check(int'(hi_idx) == e_hi_idx, "R6 hi_idx", 64'(hi_idx), 64'(e_hi_idx));
         for (int l = 0; l < N; l++)
            check(hi_data[l*W +: W] == hi_w[l], "R4 hi_data", 64'(hi_data[l*W +: W]), 64'(hi_w[l]));
      end
      // R8: apply both models, then compare every lane of the touched registers
      for (int l = 0; l < N; l++) begin
         if (e_lo[l]) ref_rf[e_lo_idx][l] = lo_w[l];
         if (e_hi[l]) ref_rf[e_hi_idx][l] = hi_w[l];
         if (lo_we[l] && int'(lo_idx) < P) dut_rf[lo_idx][l] = lo_data[l*W +: W];
         if (hi_we[l] && int'(hi_idx) < P) dut_rf[hi_idx][l] = hi_data[l*W +: W];
      end
      for (int l = 0; l < N; l++) begin
         check(dut_rf[e_lo_idx][l] == ref_rf[e_lo_idx][l], "R8 retain lo reg",
               64'(dut_rf[e_lo_idx][l]), 64'(ref_rf[e_lo_idx][l]));
         check(dut_rf[e_hi_idx][l] == ref_rf[e_hi_idx][l], "R8 retain hi reg",
               64'(dut_rf[e_hi_idx][l]), 64'(ref_rf[e_hi_idx][l]));
      end
   endtask

   initial begin
      for (int r = 0; r < P; r++)
         for (int l = 0; l < N; l++) begin
            ref_rf[r][l] = 32'(r * 256 + l);
            dut_rf[r][l] = 32'(r * 256 + l);
         end
      rst_n = 1'b0; wb_valid = 1'b1; wb_wide = 1'b1; wb_dst = '0; wave_base = '0;
      is_load = 1'b0; ignore_exec = 1'b1; wave_exec = '1; inst_exec = '1; wb_data = '0;
      repeat (3) @(negedge clk);
      // R10: strobes held low in reset even with a request presented
      check(lo_we == '0, "R10 reset lo_we", 64'(lo_we), 64'(0));
      check(hi_we == '0, "R10 reset hi_we", 64'(hi_we), 64'(0));
      wb_valid = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      check(lo_we == '0 && hi_we == '0, "R10 first cycle after reset",
            64'({lo_we, hi_we}), 64'(0));

      // R1: every live mask, non-load, two words
      for (int m = 0; m < (1 << N); m++)
         do_wb(1, 1, m % P, 3, 0, 0, N'(m), N'(~m), m);
      // R2: every captured mask on loads, live mask opposite
      for (int m = 0; m < (1 << N); m++)
         do_wb(1, m % 2, (m * 5) % P, (m * 7) % P, 1, 0, N'(~m), N'(m), m + 1000);
      // R3: ignore-exec with empty masks
      do_wb(1, 1, 4, 2, 0, 1, '0, '0, 77);
      do_wb(1, 0, 9, 1, 1, 1, '0, '0, 78);
      // R6: wrap at the last physical register, both sum paths
      do_wb(1, 1, 11, 0, 0, 0, 8'hA5, '0, 90);
      do_wb(1, 1, 6, 5, 0, 0, 8'h3C, '0, 91);
      do_wb(1, 1, 11, 11, 1, 0, '0, 8'hFF, 92);
      // R7: idle cycles with masks open
      do_wb(0, 1, 2, 2, 0, 1, '1, '1, 93);
      do_wb(0, 0, 5, 0, 1, 0, '1, '1, 94);
      // Mixed sweep over all controls
      for (int t = 0; t < 600; t++)
         do_wb((t % 11) != 3, t[0], t % P, (t / P) % P, t[1], (t % 7) == 0,
               N'(t * 37), N'(t * 91 + 5), t + 2000);

      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule